// File: doc/BRIEF.md
# Cache Cycle Arbiter

The cache controller carries out one kind of cycle per clock, and this block decides which one. Eleven request sources compete. Four are internal or urgent: the dump-second-pair cycle that follows a fetch miss, the urgent I/O probe, the whole-cache flush step and the bypass that forwards a freshly arrived word. The others are the line-fill write, the data fetch, the store probe, the two-instruction and one-instruction fetches, the execution-unit store and the relaxed I/O probe. Requests are levels. A request that loses stays asserted and is served in a later cycle. Each clock the block returns a one-hot grant, or no grant when nothing is requested.

The line-fill write is not requested from outside. A line from main memory comes back as word pairs. Each pair raises a one-cycle ready pulse once both of its words are present. The block keeps a pending flag for each pair and raises its own fill-write request while any pair is waiting. It writes pairs in the order they arrived. With each fill-write grant it reports which pair to write. It also flags whether this is the first write of the fill, which tells the datapath to mark the unwritten pair invalid and clean.

Top module: `cache_cyc_arb`

## Requirements
- R1: `gnt_o` has at most one bit set in every cycle, and is all zero while reset is held or when no effective request is present.
- R2: Grant bits use a fixed order, and the lowest-numbered asserted effective request wins: 0 dump-second-pair, 1 urgent I/O, 2 cache flush step, 3 read bypass, 4 line-fill write, 5 data fetch, 6 store probe, 7 two-instruction fetch, 8 execution-unit store, 9 one-instruction fetch, 10 relaxed I/O.
- R3: `req_i[4]` has no effect. The effective request at position 4 is asserted exactly when at least one word pair is pending.
- R4: An asserted `req_i[0]` is always granted in the same cycle.
- R5: A pulse on `pair_rdy_i[k]` makes pair k pending. A line-fill write grant is never given for a pair that is not pending.
- R6: Pending pairs are written in arrival order. Pairs that become ready in the same cycle are ordered by ascending index. `mst_pair_o` gives the pair index during a line-fill write grant.
- R7: During a line-fill write grant, `mst_first_o` is 1 for the 1st, 3rd, 5th... such grant since reset and 0 for the others. When `gnt_o[4]` is 0, `mst_pair_o` and `mst_first_o` are both 0.
- R8: A line-fill write grant clears that pair's pending flag, so each arrival produces exactly one write.
- R9: A held request that loses arbitration is granted once every higher-priority request has dropped.
- R10: While a cache flush step request is held, an urgent I/O request takes the cycle, and flush steps resume the cycle after it drops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 11 | Level requests in priority order (bit 4 unused) |
| pair_rdy_i | input | N_PAIR | One-cycle pulse: both words of pair k have arrived |
| gnt_o | output | 11 | One-hot grant for this cycle |
| mst_pair_o | output | $clog2(N_PAIR) | Pair to write with a line-fill write grant |
| mst_first_o | output | 1 | First write of a fill (invalidate and clean the other pair) |

## Verification
The bench uses the default of two word pairs, which keeps the pending state small. With that setting it drives every one of the 2048 request patterns against every one of the four pair-arrival patterns. Because the patterns run in sequence, every request set meets the empty, one-pending and two-pending fill states, and fill writes interleave with new arrivals. Directed sequences cover the corner cases. These are reversed arrival order, simultaneous arrival, urgent I/O cutting between flush steps, and the ignored request bit.

// File: rtl/cca_pkg.sv
package cca_pkg;
  localparam int NUM_CYC       = 11;
  localparam int CYC_DUMP2     = 0;
  localparam int CYC_IO_FAST   = 1;
  localparam int CYC_CDUMP     = 2;
  localparam int CYC_RD_AROUND = 3;
  localparam int CYC_MSTORE    = 4;
  localparam int CYC_EFETCH    = 5;
  localparam int CYC_SCHK      = 6;
  localparam int CYC_IFETCH2   = 7;
  localparam int CYC_ESTORE    = 8;
  localparam int CYC_IFETCH1   = 9;
  localparam int CYC_IO_SLOW   = 10;
endpackage

// File: rtl/cca_prio_enc.sv
module cca_prio_enc #(
  parameter int W = 11
) (
  input  logic [W-1:0] req_i,
  output logic [W-1:0] gnt_o
);
  // taken[i]: some lane below i is requesting
  logic [W-1:0] taken;
  assign taken[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_lane
    assign gnt_o[i] = req_i[i] & ~taken[i];
    if (i < W - 1) begin : g_nxt
      assign taken[i+1] = taken[i] | req_i[i];
    end
  end
endmodule

// File: rtl/cca_pair_seq.sv
module cca_pair_seq #(
  parameter  int N_PAIR = 2,
  localparam int PW     = $clog2(N_PAIR)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PAIR-1:0] rdy_i,
  input  logic              take_i,
  output logic              req_o,
  output logic [PW-1:0]     pair_o,
  output logic              first_o,
  output logic [N_PAIR-1:0] pend_o
);
  // Arrival stamps modulo N_PAIR; next pair to write carries stamp == st_cnt_q.
  logic [N_PAIR-1:0] pend_q;
  logic [PW-1:0]     stamp_q [N_PAIR];
  logic [PW-1:0]     arr_cnt_q, st_cnt_q;
  logic [PW-1:0]     rank [N_PAIR];
  logic [PW-1:0]     arr_sum;
  logic [N_PAIR-1:0] head;
  logic              do_take;

  always_comb begin
    logic [PW-1:0] acc;
    acc = '0;
    for (int k = 0; k < N_PAIR; k++) begin
      rank[k] = acc;
      acc     = acc + PW'(rdy_i[k]);
    end
    arr_sum = acc;
  end

  for (genvar k = 0; k < N_PAIR; k++) begin : g_pair
    assign head[k] = pend_q[k] && (stamp_q[k] == st_cnt_q);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_q[k]  <= 1'b0;
        stamp_q[k] <= '0;
      end else begin
        pend_q[k] <= (pend_q[k] & ~(do_take & head[k])) | rdy_i[k];
        if (rdy_i[k]) stamp_q[k] <= arr_cnt_q + rank[k];
      end
    end
  end

  always_comb begin
    pair_o = '0;
    for (int k = 0; k < N_PAIR; k++) begin
      if (head[k]) pair_o = PW'(k);
    end
  end

  assign req_o   = |head;
  assign do_take = take_i & req_o;
  assign first_o = (st_cnt_q == '0);
  assign pend_o  = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arr_cnt_q <= '0;
      st_cnt_q  <= '0;
    end else begin
      arr_cnt_q <= arr_cnt_q + arr_sum;
      if (do_take) st_cnt_q <= st_cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/cache_cyc_arb.sv
module cache_cyc_arb
  import cca_pkg::*;
#(
  parameter  int N_PAIR = 2,
  localparam int PW     = $clog2(N_PAIR)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_CYC-1:0] req_i,
  input  logic [N_PAIR-1:0]  pair_rdy_i,
  output logic [NUM_CYC-1:0] gnt_o,
  output logic [PW-1:0]      mst_pair_o,
  output logic               mst_first_o
);
  logic               mst_req;
  logic [PW-1:0]      mst_pair;
  logic               mst_first;
  logic [N_PAIR-1:0]  pend;
  logic [NUM_CYC-1:0] req_eff;
  logic [NUM_CYC-1:0] gnt;

  always_comb begin
    req_eff             = req_i;
    req_eff[CYC_MSTORE] = mst_req;  // fill write is sourced internally
  end

  cca_prio_enc #(.W(NUM_CYC)) u_enc (
    .req_i (req_eff),
    .gnt_o (gnt)
  );

  cca_pair_seq #(.N_PAIR(N_PAIR)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rdy_i   (pair_rdy_i),
    .take_i  (gnt[CYC_MSTORE]),
    .req_o   (mst_req),
    .pair_o  (mst_pair),
    .first_o (mst_first),
    .pend_o  (pend)
  );

  assign gnt_o       = rst_ni ? gnt : '0;
  assign mst_pair_o  = gnt_o[CYC_MSTORE] ? mst_pair : '0;
  assign mst_first_o = gnt_o[CYC_MSTORE] & mst_first;
endmodule

// File: rtl/cca_chk.sv
module cca_chk
  import cca_pkg::*;
#(
  parameter  int N_PAIR = 2,
  localparam int PW     = $clog2(N_PAIR)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_CYC-1:0] req_i,
  input logic [NUM_CYC-1:0] gnt_o,
  input logic [PW-1:0]      mst_pair_o,
  input logic               mst_first_o,
  input logic [N_PAIR-1:0]  pend_i
);
  // R1
  one_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));

  // R2
  mst_below_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_o[CYC_MSTORE] |-> (req_i[CYC_RD_AROUND:0] == '0));

  // R2
  slow_io_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_o[CYC_IO_SLOW] |-> (req_i[CYC_IFETCH1:CYC_EFETCH] == '0) && (pend_i == '0));

  // R3
  mst_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend_i != '0) && (req_i[CYC_RD_AROUND:0] == '0)) |-> gnt_o[CYC_MSTORE]);

  // R4
  dump2_now_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i[CYC_DUMP2] |-> gnt_o[CYC_DUMP2]);

  // R5
  mst_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_o[CYC_MSTORE] |-> pend_i[mst_pair_o]);

  // R7
  idle_fields_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gnt_o[CYC_MSTORE] |-> (mst_pair_o == '0) && !mst_first_o);

  // R8
  pend_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_o[CYC_MSTORE] |=> !pend_i[$past(mst_pair_o)]);
endmodule

bind cache_cyc_arb cca_chk #(.N_PAIR(N_PAIR)) u_cca_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .gnt_o       (gnt_o),
  .mst_pair_o  (mst_pair_o),
  .mst_first_o (mst_first_o),
  .pend_i      (pend)
);

// File: tb/tb_cache_cyc_arb.sv
`timescale 1ns/1ps
module tb_cache_cyc_arb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [10:0] req_i = '0;
  logic [1:0]  pair_rdy_i = '0;
  logic [10:0] gnt_o;
  logic [0:0]  mst_pair_o;
  logic        mst_first_o;

  cache_cyc_arb #(.N_PAIR(2)) dut (
    .clk_i, .rst_ni, .req_i, .pair_rdy_i, .gnt_o, .mst_pair_o, .mst_first_o
  );

  always #2.5 clk_i = ~clk_i;

  int checks = 0, fails = 0;
  int q [2];
  int qn = 0, st_cnt = 0;
  logic [10:0] og;
  int op;
  logic of;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [10:0] exp_gnt(input logic [10:0] r, input bit m);
    logic [10:0] e;
    e    = r;
    e[4] = m;
    for (int i = 0; i < 11; i++) if (e[i]) return 11'(1) << i;
    return '0;
  endfunction

  task automatic step(input logic [10:0] r, input logic [1:0] a);
    logic [1:0]  pm, am;
    logic [10:0] eg;
    @(negedge clk_i);
    pm = '0;
    for (int i = 0; i < qn; i++) pm[q[i]] = 1'b1;
    am = a & ~pm;
    req_i = r;
    pair_rdy_i = am;
    #1;
    og = gnt_o; op = int'(mst_pair_o); of = mst_first_o;
    eg = exp_gnt(r, qn > 0);
    chk("R2 grant", int'(og), int'(eg));
    chk("R1 onehot", int'($countones(og) <= 1), 1);
    if (eg[4]) begin
      chk("R6 pair", op, q[0]);
      chk("R7 first", int'(of), int'(st_cnt % 2 == 0));
      q[0] = q[1]; qn--; st_cnt++;
    end else begin
      chk("R7 idle pair", op, 0);
      chk("R7 idle first", int'(of), 0);
    end
    for (int i = 0; i < 2; i++) if (am[i]) begin q[qn] = i; qn++; end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; req_i = '0; pair_rdy_i = '0; qn = 0; st_cnt = 0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog actual=expired expected=done");
    summary();
    $finish;
  end

  initial begin
    #1;
    req_i = 11'h7ff;
    #1;
    chk("R1 reset grant", int'(gnt_o), 0);
    chk("R7 reset first", int'(mst_first_o), 0);
    do_reset();

    step(11'h7ff, 2'b00); chk("R4 dump2 wins all", int'(og), 1);
    step(11'h010, 2'b00); chk("R3 bit4 ignored", int'(og), 0);
    step(11'h010, 2'b00); chk("R5 no fill write unarrived", int'(og), 0);
    step(11'h004, 2'b00); chk("R10 flush", int'(og), 4);
    step(11'h006, 2'b00); chk("R10 io cuts in", int'(og), 2);
    step(11'h004, 2'b00); chk("R10 flush resumes", int'(og), 4);
    step(11'h202, 2'b00); chk("R9 loser held", int'(og), 2);
    step(11'h200, 2'b00); chk("R9 loser granted", int'(og), 11'h200);

    // reverse arrival order
    step(11'h001, 2'b10);
    step(11'h001, 2'b01);
    step(11'h000, 2'b00);
    chk("R6 older pair first", op, 1);
    chk("R7 first write flag", int'(of), 1);
    step(11'h000, 2'b00);
    chk("R6 second pair", op, 0);
    chk("R7 second write flag", int'(of), 0);
    step(11'h000, 2'b00);
    chk("R8 pending cleared", int'(og), 0);

    // simultaneous arrival
    step(11'h001, 2'b11);
    step(11'h000, 2'b00);
    chk("R6 tie low index", op, 0);
    chk("R5 write granted", int'(og), 11'h010);
    step(11'h000, 2'b00);
    chk("R6 tie high index", op, 1);
    step(11'h000, 2'b00);
    chk("R8 no extra write", int'(og), 0);

    do_reset();
    for (int p = 0; p < 2048; p++)
      for (int a = 0; a < 4; a++)
        step(11'(p), 2'(a));
    step(11'h000, 2'b00);
    step(11'h000, 2'b00);
    step(11'h000, 2'b00);
    chk("R8 drained", qn, 0);
    chk("R8 idle after drain", int'(og), 0);

    summary();
    $finish;
  end
endmodule